// File: doc/BRIEF.md
# Byte FIFO with Threshold Flag

This block is the data buffer that sits between a bus-side register port and the serial shifter of a flash controller. It holds 16 bytes. The bus side moves 1, 2 or 4 bytes per access. The serial side moves one byte per handshake. The direction follows the transfer mode:

- In write mode, bus writes fill the buffer and the shifter drains it.
- In read mode, the shifter fills the buffer and bus reads drain it.

The threshold flag compares the buffer state with a programmable level. It drives an interrupt line and a DMA request line, each through its own enable. In read mode the flag also rises at the end of the data phase while bytes remain in the buffer. This lets software or DMA collect a short tail.

In read mode a full buffer asserts a serial-clock stall so that the shifter cannot overrun it. The stall holds until more than four bytes of space are free again. This hysteresis avoids toggling the serial clock on every byte. An abort, or any change of mode, empties the buffer at once.

Top module: `flash_byte_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, the fill count is 0. The stall, bus wait and serial valid outputs are low. With the threshold level at 15 the threshold flag is also low.
- R2: In write mode (mode_rd=0), a bus write with size code 0, 1 or 2 stores 1, 2 or 4 bytes of bus_wdata, lowest byte first. A size code of 3 acts like code 2. The serial side then presents the bytes on ser_rd_data in the order stored, one byte per ser_rd_ready cycle.
- R3: In write mode, a bus write wider than the free space raises bus_wait in the same cycle and stores nothing.
- R4: In read mode (mode_rd=1), each accepted serial byte is appended to the buffer. A bus read of 1, 2 or 4 bytes returns the oldest bytes on bus_rdata, oldest byte in bits 7:0, with unused lanes zero, and removes them. If fewer bytes are held than requested, bus_wait is high and nothing is removed.
- R5: In read mode the threshold flag is high whenever the fill count is at least thr_lvl+1.
- R6: In read mode, a phase_done pulse makes the threshold flag high from the next cycle on, for as long as the buffer is not empty.
- R7: In write mode the threshold flag is high whenever the free space (16 minus the fill count) is strictly greater than thr_lvl+1.
- R8: irq equals the threshold flag gated by irq_en. dma_req equals the threshold flag gated by dma_en.
- R9: In read mode, sck_stall rises in the cycle the fill count reaches 16. Serial bytes offered while sck_stall is high are not stored.
- R10: Once raised, sck_stall stays high until the free space exceeds 4 (fill count 11 or less). A count of 12 keeps it high.
- R11: An abort pulse, or any change of mode_rd, empties the buffer on the next edge. It also clears the stall and the pending end-of-phase condition, and the same cycle's transfers are dropped.
- R12: Transfers in the wrong direction for the current mode have no effect on the buffer: bus writes and ser_rd_ready in read mode, and bus reads and ser_wr_valid in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_rd | input | 1 | 1 = indirect read, 0 = indirect write |
| abort | input | 1 | Flush pulse |
| thr_lvl | input | 4 | Threshold minus one |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| bus_wdata | input | 32 | Bus write data, little-endian |
| bus_rdata | output | 32 | Bus read data, little-endian |
| bus_wait | output | 1 | Access cannot complete this cycle |
| ser_wr_valid | input | 1 | Shifter offers a received byte |
| ser_wr_data | input | 8 | Received byte |
| ser_rd_ready | input | 1 | Shifter takes a byte to send |
| ser_rd_valid | output | 1 | A byte is available to send |
| ser_rd_data | output | 8 | Byte to send |
| phase_done | input | 1 | Data phase has completed |
| fill_count | output | 5 | Bytes held |
| thr_flag | output | 1 | Threshold flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| sck_stall | output | 1 | Stop serial clock |

## Verification
A pointer or count that goes wrong shows up on fill_count one cycle after the faulty access. It shows up on bus_rdata or ser_rd_data at the next read, as bytes out of order or lost. A wrong stall register shows up on sck_stall in the cycle the count reaches 16 or drops to 11. It then lets an extra byte enter or blocks one, which fill_count exposes on the following edge. A lost end-of-phase bit shows on thr_flag in the cycle after phase_done, and the bench compares every output every cycle against a byte-queue model.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } fbf_size_e;

   localparam int unsigned LANES = 4;

   function automatic logic [2:0] fbf_bytes(input logic [1:0] code);
      case (fbf_size_e'(code))
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/fbf_store.sv
module fbf_store #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush,
   input  logic [2:0]                     push_n,
   input  logic [8*fbf_pkg::LANES-1:0]    push_data,
   input  logic [2:0]                     pop_n,
   output logic [8*fbf_pkg::LANES-1:0]    head_data,
   output logic [CW-1:0]                  count,
   output logic [CW-1:0]                  count_nxt
);
   import fbf_pkg::*;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 8) begin : g_bad_depth
      $error("fbf_store: DEPTH must be a power of two and at least 8");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   assign count_nxt = flush ? '0 : count + CW'(push_n) - CW'(pop_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         wptr  <= wptr + AW'(push_n);
         rptr  <= rptr + AW'(pop_n);
         count <= count_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!flush) begin
         for (int i = 0; i < LANES; i++) begin
            if (3'(i) < push_n) mem[wptr + AW'(i)] <= push_data[8*i +: 8];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign head_data[8*g +: 8] = (CW'(g) < count) ? mem[rptr + AW'(g)] : 8'h00;
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(push_n) <= CW'(DEPTH) - count + CW'(pop_n));
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= count);
   p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0);
endmodule

// File: rtl/fbf_flag.sv
module fbf_flag #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          rd_mode,
   input  logic          phase_done,
   input  logic [CW-1:0] count,
   input  logic [AW-1:0] thr_lvl,
   input  logic          irq_en,
   input  logic          dma_en,
   output logic          thr_flag,
   output logic          irq,
   output logic          dma_req
);
   logic          tail_q;
   logic [CW-1:0] thr, space;

   assign thr   = CW'(thr_lvl) + CW'(1);
   assign space = CW'(DEPTH) - count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tail_q <= 1'b0;
      else if (flush)                   tail_q <= 1'b0;
      else if (phase_done && rd_mode)   tail_q <= 1'b1;
      else if (count == '0)             tail_q <= 1'b0;
   end

   always_comb begin
      if (rd_mode) thr_flag = (count >= thr) || (tail_q && count != '0);
      else         thr_flag = space > thr;
   end

   assign irq     = thr_flag & irq_en;
   assign dma_req = thr_flag & dma_en;

   p_tail_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode && $past(rd_mode) && $past(phase_done) && !$past(flush) && count != '0)
      |-> thr_flag);
endmodule

// File: rtl/fbf_stall.sv
module fbf_stall #(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned RESUME_GAP = 4,
   localparam int unsigned CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          rd_mode,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] count_nxt,
   output logic          sck_stall
);
   if (RESUME_GAP >= DEPTH) begin : g_bad_gap
      $error("fbf_stall: RESUME_GAP must be below DEPTH");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        sck_stall <= 1'b0;
      else if (flush || !rd_mode)                        sck_stall <= 1'b0;
      else if (count_nxt == CW'(DEPTH))                  sck_stall <= 1'b1;
      else if (CW'(DEPTH) - count_nxt > CW'(RESUME_GAP)) sck_stall <= 1'b0;
   end

   p_stall_at_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_stall) |-> count == CW'(DEPTH));
   p_release_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck_stall) |-> (count == '0 || CW'(DEPTH) - count > CW'(RESUME_GAP)));
endmodule

// File: rtl/flash_byte_fifo.sv
module flash_byte_fifo #(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned RESUME_GAP = 4,
   parameter bit          STALL_EN   = 1'b1,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_rd,
   input  logic          abort,
   input  logic [AW-1:0] thr_lvl,
   input  logic          irq_en,
   input  logic          dma_en,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [1:0]    bus_size,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          bus_wait,
   input  logic          ser_wr_valid,
   input  logic [7:0]    ser_wr_data,
   input  logic          ser_rd_ready,
   output logic          ser_rd_valid,
   output logic [7:0]    ser_rd_data,
   input  logic          phase_done,
   output logic [CW-1:0] fill_count,
   output logic          thr_flag,
   output logic          irq,
   output logic          dma_req,
   output logic          sck_stall
);
   import fbf_pkg::*;

   logic          mode_q, flush;
   logic [2:0]    nb, push_n, pop_n;
   logic [CW-1:0] cnt, cnt_nxt, space;
   logic [31:0]   head;
   logic          ser_take, ser_give, bus_push, bus_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= mode_rd;
   end

   assign flush    = abort || (mode_rd != mode_q);
   assign nb       = fbf_bytes(bus_size);
   assign space    = CW'(DEPTH) - cnt;
   assign ser_take = mode_rd && ser_wr_valid && !sck_stall && cnt != CW'(DEPTH);
   assign bus_pop  = mode_rd && bus_rd && cnt >= CW'(nb);
   assign bus_push = !mode_rd && bus_wr && space >= CW'(nb);
   assign ser_give = !mode_rd && ser_rd_ready && cnt != '0;
   assign push_n   = ser_take ? 3'd1 : (bus_push ? nb : 3'd0);
   assign pop_n    = bus_pop ? nb : (ser_give ? 3'd1 : 3'd0);
   assign bus_wait = (mode_rd && bus_rd && cnt < CW'(nb)) ||
                     (!mode_rd && bus_wr && space < CW'(nb));

   always_comb begin
      for (int i = 0; i < LANES; i++)
         bus_rdata[8*i +: 8] = (mode_rd && 3'(i) < nb) ? head[8*i +: 8] : 8'h00;
   end

   assign ser_rd_valid = !mode_rd && cnt != '0;
   assign ser_rd_data  = head[7:0];
   assign fill_count   = cnt;

   fbf_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push_n(push_n), .push_data(mode_rd ? {24'h0, ser_wr_data} : bus_wdata),
      .pop_n(pop_n), .head_data(head), .count(cnt), .count_nxt(cnt_nxt)
   );

   fbf_flag #(.DEPTH(DEPTH)) u_flag (
      .clk(clk), .rst_n(rst_n), .flush(flush), .rd_mode(mode_rd),
      .phase_done(phase_done), .count(cnt), .thr_lvl(thr_lvl),
      .irq_en(irq_en), .dma_en(dma_en),
      .thr_flag(thr_flag), .irq(irq), .dma_req(dma_req)
   );

   if (STALL_EN) begin : g_stall
      fbf_stall #(.DEPTH(DEPTH), .RESUME_GAP(RESUME_GAP)) u_stall (
         .clk(clk), .rst_n(rst_n), .flush(flush), .rd_mode(mode_rd),
         .count(cnt), .count_nxt(cnt_nxt), .sck_stall(sck_stall)
      );
   end else begin : g_no_stall
      assign sck_stall = 1'b0;
   end

   p_stall_blocks_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sck_stall |=> cnt <= $past(cnt));
   p_wrong_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_rd && !flush && !bus_wr && !ser_rd_ready) |=> cnt == $past(cnt));
endmodule

// File: tb/flash_byte_fifo_bench.sv
module flash_byte_fifo_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic d_mode = 0, d_abort = 0, d_ie = 0, d_de = 0, d_bw = 0, d_br = 0;
   logic [3:0] d_lvl = 4'd15;
   logic [1:0] d_sz = 0;
   logic [31:0] d_wd = 0;
   logic d_sv = 0, d_sr = 0, d_pd = 0;
   logic [7:0] d_sd = 0;
   logic [31:0] bus_rdata;
   logic bus_wait, ser_rd_valid, thr_flag, irq, dma_req, sck_stall;
   logic [7:0] ser_rd_data;
   logic [4:0] fill_count;

   int checks = 0, errors = 0;
   bit done = 0;
   byte unsigned ref_q[$];
   bit m_mode = 0, m_tail = 0, m_stall = 0;

   always #5 clk = ~clk;

   flash_byte_fifo u_flash_byte_fifo (
      .clk(clk), .rst_n(rst_n), .mode_rd(d_mode), .abort(d_abort), .thr_lvl(d_lvl),
      .irq_en(d_ie), .dma_en(d_de), .bus_wr(d_bw), .bus_rd(d_br), .bus_size(d_sz),
      .bus_wdata(d_wd), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
      .ser_wr_valid(d_sv), .ser_wr_data(d_sd), .ser_rd_ready(d_sr),
      .ser_rd_valid(ser_rd_valid), .ser_rd_data(ser_rd_data), .phase_done(d_pd),
      .fill_count(fill_count), .thr_flag(thr_flag), .irq(irq), .dma_req(dma_req),
      .sck_stall(sck_stall)
   );

   task automatic chk(input string tag, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
      end
   endtask

   function automatic int nbytes(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   function automatic bit exp_flag();
      int s = ref_q.size();
      int t = int'(d_lvl) + 1;
      if (m_mode) return (s >= t) || (m_tail && s > 0);
      return (16 - s) > t;
   endfunction

   task automatic idle();
      d_abort = 0; d_bw = 0; d_br = 0; d_sv = 0; d_sr = 0; d_pd = 0; d_sz = 0;
   endtask

   task automatic model_edge();
      int sz, nb, ns;
      bit fl, tail_n;
      sz = ref_q.size();
      nb = nbytes(d_sz);
      fl = d_abort || (d_mode != m_mode);
      if (fl) begin
         ref_q.delete(); m_tail = 0; m_stall = 0;
      end else begin
         tail_n = m_tail;
         if (d_pd && d_mode) tail_n = 1;
         else if (sz == 0) tail_n = 0;
         if (d_mode) begin
            if (d_br && sz >= nb) for (int k = 0; k < nb; k++) void'(ref_q.pop_front());
            if (d_sv && !m_stall && sz < 16) ref_q.push_back(d_sd);
         end else begin
            if (d_sr && sz > 0) void'(ref_q.pop_front());
            if (d_bw && 16 - sz >= nb)
               for (int k = 0; k < nb; k++) ref_q.push_back(d_wd[8*k +: 8]);
         end
         m_tail = tail_n;
         ns = ref_q.size();
         if (!d_mode) m_stall = 0;
         else if (ns == 16) m_stall = 1;
         else if (16 - ns > 4) m_stall = 0;
      end
      m_mode = d_mode;
   endtask

   task automatic step();
      int sz, nb;
      logic [31:0] er;
      #1;
      sz = ref_q.size();
      nb = nbytes(d_sz);
      if (d_mode && d_br) begin
         chk("R4", "bus_wait", bus_wait, sz < nb);
         if (sz >= nb) begin
            er = 0;
            for (int k = 0; k < nb; k++) er[8*k +: 8] = ref_q[k];
            chk("R4", "bus_rdata", bus_rdata, er);
         end
      end else if (!d_mode && d_bw) chk("R3", "bus_wait", bus_wait, (16 - sz) < nb);
      else chk("R12", "bus_wait idle", bus_wait, 0);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(m_mode ? "R4" : "R2", "fill_count", fill_count, ref_q.size());
      chk(m_mode ? "R5/R6" : "R7", "thr_flag", thr_flag, exp_flag());
      chk("R8", "irq", irq, exp_flag() & d_ie);
      chk("R8", "dma_req", dma_req, exp_flag() & d_de);
      chk("R9/R10", "sck_stall", sck_stall, m_stall);
      if (!m_mode) begin
         chk("R2", "ser_rd_valid", ser_rd_valid, ref_q.size() != 0);
         if (ref_q.size() != 0) chk("R2", "ser_rd_data", ser_rd_data, ref_q[0]);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #2ms;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk("R1", "count in reset", fill_count, 0);
      chk("R1", "stall in reset", sck_stall, 0);
      chk("R1", "flag in reset", thr_flag, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "count after reset", fill_count, 0);
      chk("R1", "valid after reset", ser_rd_valid, 0);
      chk("R1", "wait after reset", bus_wait, 0);

      // R2: mixed widths, little-endian order
      d_lvl = 4'd7; d_ie = 1; d_de = 1;
      idle(); d_bw = 1; d_sz = 2; d_wd = 32'h4433_2211; step();
      d_sz = 1; d_wd = 32'hAAAA_6655; step();
      d_sz = 0; d_wd = 32'hBBBB_BB77; step();
      idle(); step();
      chk("R2", "seven bytes stored", fill_count, 7);
      for (int k = 0; k < 7; k++) begin
         chk("R2", "byte order", ser_rd_data, 8'h11 * (k + 1));
         d_sr = 1; step();
      end
      idle();
      // R3: overfill in write mode
      d_bw = 1; d_sz = 2;
      for (int k = 0; k < 5; k++) begin d_wd = 32'h0101_0101 * (k + 1); step(); end
      idle(); step();
      chk("R3", "count held at 16", fill_count, 16);

      // R11: mode change flushes
      d_mode = 1; step();
      chk("R11", "flush on mode change", fill_count, 0);
      // R9: fill to full, extra byte ignored
      d_lvl = 4'd15;
      for (int k = 0; k < 17; k++) begin d_sv = 1; d_sd = 8'(k + 8'h30); step(); end
      d_sv = 0;
      chk("R9", "stall at full", sck_stall, 1);
      chk("R9", "extra byte dropped", fill_count, 16);
      // R10: release hysteresis
      d_br = 1; d_sz = 2; step(); d_br = 0;
      chk("R10", "still stalled at 12", sck_stall, 1);
      d_sv = 1; d_sd = 8'hEE; step(); d_sv = 0;
      chk("R10", "no push while stalled", fill_count, 12);
      d_br = 1; d_sz = 0; step(); d_br = 0;
      chk("R10", "released at 11", sck_stall, 0);
      // R12: wrong-direction writes in read mode
      d_bw = 1; d_sz = 2; d_sr = 1; step(); idle();
      chk("R12", "read mode ignores bus write", fill_count, 11);
      // R11: abort
      d_abort = 1; step(); idle();
      chk("R11", "abort empties", fill_count, 0);
      // R5: threshold sweep
      for (int lv = 0; lv < 16; lv++) begin
         d_lvl = 4'(lv);
         d_abort = 1; step(); d_abort = 0;
         for (int k = 0; k < 16; k++) begin d_sv = 1; d_sd = 8'(k); step(); end
         d_sv = 0;
      end
      // R6: end of phase with a short tail
      d_abort = 1; step(); d_abort = 0;
      d_lvl = 4'd15;
      for (int k = 0; k < 3; k++) begin d_sv = 1; d_sd = 8'(k); step(); end
      d_sv = 0;
      chk("R6", "no flag before phase end", thr_flag, 0);
      d_pd = 1; step(); d_pd = 0;
      chk("R6", "flag after phase end", thr_flag, 1);
      for (int k = 0; k < 3; k++) begin d_br = 1; d_sz = 0; step(); end
      idle(); step();
      chk("R6", "flag gone once empty", thr_flag, 0);
      // R12: serial byte in write mode
      d_mode = 0; step();
      d_sv = 1; d_br = 1; d_sz = 0; step(); idle();
      chk("R12", "write mode ignores serial byte", fill_count, 0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         idle();
         if ($urandom_range(199) == 0) d_mode = ~d_mode;
         if ($urandom_range(299) == 0) d_abort = 1;
         if ($urandom_range(99) == 0) d_lvl = 4'($urandom_range(15));
         d_ie = 1'($urandom_range(1));
         d_de = 1'($urandom_range(1));
         d_sz = 2'($urandom_range(3));
         d_wd = $urandom();
         d_sd = 8'($urandom_range(255));
         if (d_mode) begin
            d_sv = ($urandom_range(9) < 6);
            d_br = ($urandom_range(9) < 4);
            d_pd = ($urandom_range(49) == 0);
            d_bw = ($urandom_range(19) == 0);
         end else begin
            d_bw = ($urandom_range(9) < 5);
            d_sr = ($urandom_range(9) < 4);
            d_sv = ($urandom_range(19) == 0);
         end
         step();
      end
      done = 1;
      summary();
      $finish;
   end
endmodule